// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration front end of a multi-function peripheral controller. A host reaches it through a two-byte I/O window: the even address takes a register index, the next address moves register data. The window base is chosen by a strap pin between two fixed locations. Until the host writes an unlock key to the index port twice in a row, the window is locked and data access does nothing useful. A separate lock key written to the index port closes it again.

While unlocked, the host writes an index and then reads or writes data at that index. Indexes below a local boundary hold the global registers. These are a writable device-select register and read-only identity words: the chip identity, a revision and the vendor identity. Indexes at or above the boundary are forwarded over a simple single-cycle internal bus to the register bank of the currently selected logical device. The selector value rides along on that bus. The chip identity is chosen at elaboration from the number of pin banks the build carries.

Top module: `cfg_port`

## Requirements
- R1: After reset the port is locked, the index is 0 and the device select output `dev_ldn` is 0.
- R2: With `base_strap` low the window is at 0x2E/0x2F; with it high, at 0x4E/0x4F. Accesses anywhere else have no effect, and `io_claim` is high only for a read inside the window.
- R3: Only two consecutive index-port writes of 0x87 unlock the port. Any other index-port write while locked clears a pending first key.
- R4: An index-port write of 0xAA while unlocked locks the port; the index is left unchanged.
- R5: While locked, reads of either port return 0xFF, and data writes change no register and raise no `dev_wr`/`dev_rd`.
- R6: Index 0x07 is the device select. A data write there sets `dev_ldn` from the next clock edge, and a data read returns it.
- R7: Index 0x20 reads the chip identity high byte and 0x21 the low byte (0x0541 for a 5-bank build, 0x0909 for an 8-bank build). Index 0x22 reads the revision (0x11 by default).
- R8: Index 0x23 reads 0x19 and 0x24 reads 0x34. Other global indexes below 0x30 other than 0x07 read 0x00.
- R9: While unlocked, a data write at an index of 0x30 or higher raises `dev_wr` in the same cycle with `dev_idx` equal to the index and `dev_wdata` equal to the written byte. A data read there raises `dev_rd` and returns `dev_rdata` in the same cycle.
- R10: Data writes to the read-only identity indexes 0x20 to 0x24 leave their read values unchanged.
- R11: An index-port read returns the current index while unlocked and 0xFF while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_strap | input | 1 | Selects window base: 0 gives 0x2E, 1 gives 0x4E |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, valid while `io_rd` is high |
| io_claim | output | 1 | High when the current read falls in the window |
| dev_ldn | output | 8 | Current logical device select |
| dev_idx | output | 8 | Current index, presented to device banks |
| dev_wr | output | 1 | Device bank write strobe |
| dev_rd | output | 1 | Device bank read strobe |
| dev_wdata | output | 8 | Device bank write data |
| dev_rdata | input | 8 | Read data returned by the selected bank |

## Verification
Read data, `io_claim` and the device strobes are combinational, so they are due within the same cycle as the host strobe. The bench drives each access just after a falling edge and samples these outputs 1 ns later, before the rising edge. Effects of writes on the lock state, the index and `dev_ldn` appear after the rising edge inside the write cycle. The bench therefore observes them only through a later access. A bench model tracks the key state, index and select from the same stimulus and predicts every read value.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_ARMED  = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;

   typedef struct packed {
      logic idx_wr;
      logic idx_rd;
      logic dat_wr;
      logic dat_rd;
   } win_hit_t;

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
   import cfg_port_pkg::*;
#(
   parameter int              AW     = 16,
   parameter logic [AW-1:0]   BASE_A = 16'h002E,
   parameter logic [AW-1:0]   BASE_B = 16'h004E
) (
   input  logic          strap,
   input  logic [AW-1:0] addr,
   input  logic          wr,
   input  logic          rd,
   output win_hit_t      hit
);
   localparam logic [AW-1:0] STEP = AW'(1);

   logic [AW-1:0] base_q;
   logic          at_idx;
   logic          at_dat;

   if (BASE_A[0] || BASE_B[0]) begin : g_bad_align
      $error("window bases must be even");
   end
   if (BASE_A == BASE_B) begin : g_bad_same
      $error("window bases must differ");
   end

   always_comb begin
      base_q = strap ? BASE_B : BASE_A;
      at_idx = (addr == base_q);
      at_dat = (addr == base_q + STEP);
      hit.idx_wr = at_idx & wr;
      hit.idx_rd = at_idx & rd;
      hit.dat_wr = at_dat & wr;
      hit.dat_rd = at_dat & rd;
   end
endmodule

// File: rtl/cfg_port_keylock.sv
module cfg_port_keylock
   import cfg_port_pkg::*;
#(
   parameter int            DW        = 8,
   parameter logic [DW-1:0] KEY_OPEN  = 8'h87,
   parameter logic [DW-1:0] KEY_CLOSE = 8'hAA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          idx_wr,
   input  logic [DW-1:0] wdata,
   output logic          unlocked
);
   key_state_e st_q, st_d;

   if (KEY_OPEN == KEY_CLOSE) begin : g_bad_keys
      $error("open and close keys must differ");
   end

   always_comb begin
      st_d = st_q;
      if (idx_wr) begin
         unique case (st_q)
            KS_LOCKED: st_d = (wdata == KEY_OPEN)  ? KS_ARMED  : KS_LOCKED;
            KS_ARMED:  st_d = (wdata == KEY_OPEN)  ? KS_OPEN   : KS_LOCKED;
            KS_OPEN:   st_d = (wdata == KEY_CLOSE) ? KS_LOCKED : KS_OPEN;
            default:   st_d = KS_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KS_LOCKED;
      else        st_q <= st_d;
   end

   assign unlocked = (st_q == KS_OPEN);
endmodule

// File: rtl/cfg_port_regs.sv
module cfg_port_regs
   import cfg_port_pkg::*;
#(
   parameter int            DW         = 8,
   parameter int            NUM_BANKS  = 5,
   parameter logic [DW-1:0] KEY_CLOSE  = 8'hAA,
   parameter logic [DW-1:0] SEL_IDX    = 8'h07,
   parameter logic [DW-1:0] ID_IDX     = 8'h20,
   parameter logic [DW-1:0] LOCAL_BASE = 8'h30,
   parameter logic [DW-1:0] REVISION   = 8'h11,
   parameter logic [2*DW-1:0] VENDOR   = 16'h1934
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          unlocked,
   input  win_hit_t      hit,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] dev_rdata,
   output logic [DW-1:0] rdata,
   output logic [DW-1:0] sel_q,
   output logic [DW-1:0] idx_q,
   output logic          dev_wr,
   output logic          dev_rd
);
   localparam logic [DW-1:0] ID_LO  = ID_IDX + DW'(1);
   localparam logic [DW-1:0] REV_AT = ID_IDX + DW'(2);
   localparam logic [DW-1:0] VEN_HI = ID_IDX + DW'(3);
   localparam logic [DW-1:0] VEN_LO = ID_IDX + DW'(4);

   logic [2*DW-1:0] chip_id;
   logic [DW-1:0]   glob_rd;
   logic            is_local;

   if (DW < 8) begin : g_bad_dw
      $error("data width below one byte");
   end
   if (VEN_LO >= LOCAL_BASE || SEL_IDX >= ID_IDX) begin : g_bad_map
      $error("global register map overlaps device space");
   end

   if (NUM_BANKS == 8) begin : g_id8
      assign chip_id = (2*DW)'(16'h0909);
   end else if (NUM_BANKS == 5) begin : g_id5
      assign chip_id = (2*DW)'(16'h0541);
   end else begin : g_bad_banks
      $error("NUM_BANKS must be 5 or 8");
      assign chip_id = '0;
   end

   assign is_local = (idx_q >= LOCAL_BASE);
   assign dev_wr   = unlocked & hit.dat_wr & is_local;
   assign dev_rd   = unlocked & hit.dat_rd & is_local;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         sel_q <= '0;
      end else if (unlocked) begin
         if (hit.idx_wr && wdata != KEY_CLOSE) idx_q <= wdata;
         if (hit.dat_wr && idx_q == SEL_IDX)   sel_q <= wdata;
      end
   end

   always_comb begin
      unique case (idx_q)
         SEL_IDX: glob_rd = sel_q;
         ID_IDX:  glob_rd = chip_id[2*DW-1:DW];
         ID_LO:   glob_rd = chip_id[DW-1:0];
         REV_AT:  glob_rd = REVISION;
         VEN_HI:  glob_rd = VENDOR[2*DW-1:DW];
         VEN_LO:  glob_rd = VENDOR[DW-1:0];
         default: glob_rd = '0;
      endcase
   end

   always_comb begin
      rdata = '1;
      if (unlocked) begin
         if (hit.idx_rd)      rdata = idx_q;
         else if (hit.dat_rd) rdata = is_local ? dev_rdata : glob_rd;
      end
   end
endmodule

// File: rtl/cfg_port.sv
module cfg_port
   import cfg_port_pkg::*;
#(
   parameter int            AW        = 16,
   parameter int            DW        = 8,
   parameter int            NUM_BANKS = 5,
   parameter logic [AW-1:0] BASE_A    = 16'h002E,
   parameter logic [AW-1:0] BASE_B    = 16'h004E,
   parameter logic [DW-1:0] KEY_OPEN  = 8'h87,
   parameter logic [DW-1:0] KEY_CLOSE = 8'hAA,
   parameter logic [DW-1:0] SEL_IDX   = 8'h07,
   parameter logic [DW-1:0] LOCAL_BASE = 8'h30,
   parameter logic [DW-1:0] REVISION  = 8'h11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          base_strap,
   input  logic [AW-1:0] io_addr,
   input  logic          io_wr,
   input  logic          io_rd,
   input  logic [DW-1:0] io_wdata,
   output logic [DW-1:0] io_rdata,
   output logic          io_claim,
   output logic [DW-1:0] dev_ldn,
   output logic [DW-1:0] dev_idx,
   output logic          dev_wr,
   output logic          dev_rd,
   output logic [DW-1:0] dev_wdata,
   input  logic [DW-1:0] dev_rdata
);
   win_hit_t hit;
   logic     unlocked;
   logic     idx_wr_hit;
   logic     dat_wr_hit;

   cfg_port_decode #(.AW(AW), .BASE_A(BASE_A), .BASE_B(BASE_B)) u_dec (
      .strap (base_strap),
      .addr  (io_addr),
      .wr    (io_wr),
      .rd    (io_rd),
      .hit   (hit)
   );

   cfg_port_keylock #(.DW(DW), .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx_wr   (hit.idx_wr),
      .wdata    (io_wdata),
      .unlocked (unlocked)
   );

   cfg_port_regs #(
      .DW(DW), .NUM_BANKS(NUM_BANKS), .KEY_CLOSE(KEY_CLOSE),
      .SEL_IDX(SEL_IDX), .LOCAL_BASE(LOCAL_BASE), .REVISION(REVISION)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .unlocked  (unlocked),
      .hit       (hit),
      .wdata     (io_wdata),
      .dev_rdata (dev_rdata),
      .rdata     (io_rdata),
      .sel_q     (dev_ldn),
      .idx_q     (dev_idx),
      .dev_wr    (dev_wr),
      .dev_rd    (dev_rd)
   );

   assign idx_wr_hit = hit.idx_wr;
   assign dat_wr_hit = hit.dat_wr;
   assign io_claim   = hit.idx_rd | hit.dat_rd;
   assign dev_wdata  = io_wdata;
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
   parameter int            DW        = 8,
   parameter logic [DW-1:0] KEY_OPEN  = 8'h87,
   parameter logic [DW-1:0] KEY_CLOSE = 8'hAA,
   parameter logic [DW-1:0] SEL_IDX   = 8'h07
) (
   input logic          clk,
   input logic          rst_n,
   input logic          unlocked,
   input logic          idx_wr,
   input logic          dat_wr,
   input logic [DW-1:0] wdata,
   input logic [DW-1:0] idx,
   input logic [DW-1:0] ldn,
   input logic          dev_wr,
   input logic          dev_rd,
   input logic          io_wr,
   input logic          io_rd
);
   // R5
   locked_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |-> (!dev_wr && !dev_rd));

   // R3
   unlock_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && !$past(unlocked)) |-> ($past(idx_wr) && $past(wdata) == KEY_OPEN));

   // R4
   relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && idx_wr && wdata == KEY_CLOSE) |=> !unlocked);

   // R6
   select_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(unlocked && dat_wr && idx == SEL_IDX) |=> $stable(ldn));

   // R9
   dev_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_wr || dev_rd) |-> ($onehot0({dev_wr, dev_rd}) && (dev_wr ? io_wr : io_rd)));
endmodule

bind cfg_port cfg_port_chk #(
   .DW(DW), .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE), .SEL_IDX(SEL_IDX)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .unlocked (unlocked),
   .idx_wr   (idx_wr_hit),
   .dat_wr   (dat_wr_hit),
   .wdata    (io_wdata),
   .idx      (dev_idx),
   .ldn      (dev_ldn),
   .dev_wr   (dev_wr),
   .dev_rd   (dev_rd),
   .io_wr    (io_wr),
   .io_rd    (io_rd)
);

// File: tb/sim_cfg_port.sv
`timescale 1ns/1ps
module sim_cfg_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_strap = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        io_claim;
   logic [7:0]  dev_ldn, dev_idx, dev_wdata, dev_rdata;
   logic        dev_wr, dev_rd;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model
   bit        m_open, m_arm;
   logic [7:0] m_idx, m_ldn;
   logic [15:0] m_base;

   always #2.5 clk = ~clk;

   // stand-in device bank
   assign dev_rdata = dev_idx ^ dev_ldn ^ 8'h5A;

   cfg_port u0 (
      .clk(clk), .rst_n(rst_n), .base_strap(base_strap),
      .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .io_claim(io_claim),
      .dev_ldn(dev_ldn), .dev_idx(dev_idx), .dev_wr(dev_wr), .dev_rd(dev_rd),
      .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [15:0] a);
      if (!m_open) return 8'hFF;
      if (a == m_base) return m_idx;
      if (a != m_base + 16'd1) return 8'hFF;
      if (m_idx >= 8'h30) return m_idx ^ m_ldn ^ 8'h5A;
      case (m_idx)
         8'h07: return m_ldn;
         8'h20: return 8'h05;
         8'h21: return 8'h41;
         8'h22: return 8'h11;
         8'h23: return 8'h19;
         8'h24: return 8'h34;
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_write(input logic [15:0] a, input logic [7:0] d);
      if (a == m_base) begin
         if (!m_open) begin
            if (d == 8'h87) begin
               if (m_arm) begin m_open = 1; m_arm = 0; end
               else m_arm = 1;
            end else m_arm = 0;
         end else if (d == 8'hAA) m_open = 0;
         else m_idx = d;
      end else if (a == m_base + 16'd1 && m_open && m_idx == 8'h07) m_ldn = d;
   endtask

   task automatic do_reset(input logic strap);
      @(negedge clk);
      rst_n = 1'b0; base_strap = strap;
      m_open = 0; m_arm = 0; m_idx = 0; m_ldn = 0;
      m_base = strap ? 16'h004E : 16'h002E;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      bit exp_dw;
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      #1;
      exp_dw = m_open && a == m_base + 16'd1 && m_idx >= 8'h30;
      chk("R5/R9 dev_wr", {15'd0, dev_wr}, {15'd0, exp_dw});
      if (exp_dw) chk("R9 dev_idx/wdata", {dev_idx, dev_wdata}, {m_idx, d});
      model_write(a, d);
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read(input string req, input logic [15:0] a);
      bit in_win;
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1;
      in_win = (a == m_base) || (a == m_base + 16'd1);
      chk(req, {8'd0, io_rdata}, {8'd0, exp_read(a)});
      chk("R2 claim", {15'd0, io_claim}, {15'd0, in_win});
      chk("R9 dev_rd", {15'd0, dev_rd},
          {15'd0, m_open && a == m_base + 16'd1 && m_idx >= 8'h30});
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   task automatic rd_reg(input string req, input logic [7:0] i);
      io_write(m_base, i);
      io_read(req, m_base + 16'd1);
   endtask

   initial begin
      #900000;
      fails++;
      $display("FAIL watchdog expired");
      if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int unsigned seed_val;
      seed_val = $urandom(32'h0C0F_1E57);
      do_reset(1'b0);
      // R1 R5 R11: locked after reset
      io_read("R1 R5 data locked", 16'h002F);
      io_read("R11 index locked", 16'h002E);
      io_write(16'h002F, 8'h33);
      // R3: interrupted key does not unlock
      io_write(16'h002E, 8'h87);
      io_write(16'h002E, 8'h55);
      io_write(16'h002E, 8'h87);
      io_read("R3 interrupted key", 16'h002F);
      chk("R3 still locked", {15'd0, m_open}, 16'd0);
      // R2: keys at the wrong base
      io_write(16'h004E, 8'h87);
      io_write(16'h004E, 8'h87);
      io_read("R2 stray base", 16'h004F);
      io_write(16'h002E, 8'h87);
      io_write(16'h002E, 8'h87);
      chk("R3 open", {15'd0, m_open}, 16'd1);
      io_read("R11 index open", 16'h002E);
      rd_reg("R1 select reset", 8'h07);
      chk("R1 dev_ldn", {8'd0, dev_ldn}, 16'd0);
      rd_reg("R7 id hi", 8'h20);
      rd_reg("R7 id lo", 8'h21);
      rd_reg("R7 rev", 8'h22);
      rd_reg("R8 vendor hi", 8'h23);
      rd_reg("R8 vendor lo", 8'h24);
      rd_reg("R8 zero", 8'h2A);
      // R10: read-only identity
      io_write(16'h002E, 8'h20);
      io_write(16'h002F, 8'hC3);
      io_read("R10 id hi kept", 16'h002F);
      // R6
      io_write(16'h002E, 8'h07);
      io_write(16'h002F, 8'h06);
      #1 chk("R6 dev_ldn", {8'd0, dev_ldn}, 16'h0006);
      io_read("R6 select read", 16'h002F);
      // R9
      io_write(16'h002E, 8'h40);
      io_write(16'h002F, 8'h9C);
      io_read("R9 bank read", 16'h002F);
      // R4: relock leaves index
      io_write(16'h002E, 8'hAA);
      io_read("R4 locked", 16'h002F);
      io_write(16'h002E, 8'h87);
      io_write(16'h002E, 8'h87);
      io_read("R4 index kept", 16'h002E);
      // R5: writes while locked ignored
      io_write(16'h002E, 8'h07);
      io_write(16'h002E, 8'hAA);
      io_write(16'h002F, 8'h44);
      #1 chk("R5 select kept", {8'd0, dev_ldn}, 16'h0006);
      // constrained random traffic
      for (int n = 0; n < 1500; n++) begin
         int unsigned r, k;
         logic [15:0] a;
         logic [7:0]  d;
         r = $urandom;
         k = r % 8;
         a = (k < 4) ? m_base : (k < 7) ? m_base + 16'd1 : 16'($urandom);
         case ($urandom % 6)
            0: d = 8'h87;
            1: d = (($urandom % 4) == 0) ? 8'hAA : 8'h87;
            2: d = 8'h07;
            3: d = 8'h20 + 8'($urandom % 6);
            default: d = 8'($urandom);
         endcase
         if (r[8]) io_write(a, d);
         else      io_read("R2 R3 R5 R9 random read", a);
      end
      // R2: strapped to the upper base
      do_reset(1'b1);
      io_write(16'h002E, 8'h87);
      io_write(16'h002E, 8'h87);
      io_write(16'h004E, 8'h87);
      io_write(16'h004E, 8'h87);
      io_read("R2 upper index", 16'h004E);
      rd_reg("R2 upper id", 8'h21);
      io_read("R2 lower idle", 16'h002F);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule